// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state of a bank of interrupt sources and decides when each one turns into a delivery request for a presentation controller. Every source has a target server index, a live priority, a saved priority, a fixed type (level-sensitive wire or one-shot message) and four status flags: wire asserted, delivery outstanding, bounced back, and arrived-while-masked. A priority of 0xFF means the source is masked.

All work enters through one operation port, one operation per cycle, accepted only while `busy` is low. Wire and message events, configuration commands (set, read, mask, unmask), bounce-backs, end-of-interrupt notices and a replay command share this port. Sources are addressed by absolute number, starting at the parameter `BASE`. Deliveries leave through a registered valid/ready port that carries the server, the absolute source number and the priority. A replay command walks all sources, one per clock, and redelivers the ones that qualify.

With the default parameters there are 8 sources numbered 16 to 23. Sources 16 to 19 are message sources and 20 to 23 are level sources (`LEVEL_MASK` = 8'hF0). There are 4 servers.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, `busy`, `dlv_vld` and `rsp_vld` are low. Every source reads back through a read command (op code 2) with server 0 and priority 0xFF.
- R2: A message event (op code 0, `op_val`=1) on a source with priority 0xFF delivers nothing and records a pending arrival. A later set command (op code 1) with a priority other than 0xFF delivers it once and clears the record, so repeating the same set delivers nothing.
- R3: A message event on an unmasked source raises `dlv_vld` in the cycle after acceptance. The request carries the configured server, the absolute source number and the configured priority.
- R4: A level source copies `op_val` of each event into its asserted flag. It delivers only when its priority is not 0xFF, asserted is set and the outstanding flag is clear, and delivering sets the outstanding flag. Further assertions and a deassert/assert pair deliver nothing while the flag is set.
- R5: An end-of-interrupt command (op code 6) clears the outstanding flag of a level source and delivers nothing itself. On a message source it has no effect.
- R6: A bounce-back command (op code 5) sets the bounced flag and clears the outstanding flag. On replay, a bounced message source is redelivered once (its flag is cleared), and a still-asserted level source is redelivered.
- R7: A replay command (op code 7) holds `busy` high while it visits the sources in ascending order, one per clock when nothing is delivered. Its deliveries appear in ascending source order.
- R8: A delivery request holds its fields and keeps `busy` high until `dlv_rdy` is sampled high. Operations presented while `busy` is high are ignored and give no response.
- R9: A mask command (op code 3) sets the priority to 0xFF and saves the old priority. An unmask command (op code 4) restores the priority from the saved value and re-evaluates the source, which can deliver at once.
- R10: A configuration command whose source number is outside [`BASE`, `BASE`+`NUM_SRC`) is answered with `rsp_err`=1 and changes nothing. The same holds for a set command with a server of `NUM_SRV` or more, or with a priority above 0xFF (bit 8 of `op_prio` set).
- R11: Every accepted configuration command (op codes 1 to 4) gets `rsp_vld` in the next cycle. A read returns the stored server and priority on `rsp_server` and `rsp_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operation present |
| op_code | input | 3 | 0 event, 1 set, 2 read, 3 mask, 4 unmask, 5 bounce, 6 end-of-interrupt, 7 replay |
| op_num | input | NUM_W | Absolute source number |
| op_server | input | SRV_W | Target server for a set command |
| op_prio | input | 9 | Priority for a set command; bit 8 flags an out-of-range value |
| op_val | input | 1 | Event value (wire level or message strobe) |
| busy | output | 1 | Replay in progress or delivery waiting |
| rsp_vld | output | 1 | Configuration response valid |
| rsp_err | output | 1 | Parameter error |
| rsp_server | output | SRV_W | Server returned by a read |
| rsp_prio | output | 8 | Priority returned by a read |
| dlv_vld | output | 1 | Delivery request valid |
| dlv_rdy | input | 1 | Delivery request taken |
| dlv_server | output | SRV_W | Delivery target server |
| dlv_num | output | NUM_W | Delivery absolute source number |
| dlv_prio | output | 8 | Delivery priority |

## Verification
The main function is tried with three kinds of pattern: message strobes on masked and unmasked sources, level assert/deassert sequences with and without an end-of-interrupt between them, and mask/unmask cycles around a held level. Together they separate the two delivery rules, because only the level rule suppresses repeats and only the message rule remembers an arrival while masked. Bounce-then-replay runs show that replay picks out bounced messages and re-armed levels in ascending order and leaves everything else alone. A second replay then shows that each bounce is consumed once. Held deliveries, with operations presented against `busy`, show that nothing is lost or duplicated under backpressure.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

  typedef enum logic [2:0] {
    OP_EVENT  = 3'd0,
    OP_SET    = 3'd1,
    OP_GET    = 3'd2,
    OP_MASK   = 3'd3,
    OP_UNMASK = 3'd4,
    OP_BOUNCE = 3'd5,
    OP_EOI    = 3'd6,
    OP_REPLAY = 3'd7
  } op_e;

  typedef struct packed {
    logic asrt;   // wire currently high (level sources)
    logic sent;   // delivery outstanding (level sources)
    logic bnc;    // bounced back, awaiting replay (message sources)
    logic mpend;  // arrived while masked (message sources)
  } src_st_t;

  // level delivery rule
  function automatic logic lvl_ready(src_st_t s, logic [PRIO_W-1:0] p);
    return (p != PRIO_OFF) && s.asrt && !s.sent;
  endfunction

endpackage

// File: rtl/irq_src_range.sv
module irq_src_range #(
  parameter int NUM_SRC = 8,
  parameter int NUM_SRV = 4,
  parameter int BASE    = 16,
  parameter int NUM_W   = 12,
  parameter int SRV_W   = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_W-1:0] num,
  input  logic [SRV_W-1:0] server,
  output logic             num_ok,
  output logic             srv_ok,
  output logic [IDX_W-1:0] idx
);
  localparam logic [NUM_W-1:0] LO_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] HI_N = NUM_W'(BASE + NUM_SRC);
  localparam logic [SRV_W-1:0] SRV_LIM = SRV_W'(NUM_SRV);

  assign num_ok = (num >= LO_N) && (num < HI_N);
  assign srv_ok = server < SRV_LIM;
  assign idx    = IDX_W'(num - LO_N);
endmodule

// File: rtl/irq_src_scan.sv
module irq_src_scan #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  output logic             active,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active && step) begin
      if (idx == LAST) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end

  // R7: the walk never leaves the source range and ends after the last one
  p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx <= LAST));
  p_walk_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (active && step && !start && idx == LAST) |=> !active);
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int                   NUM_SRC    = 8,
  parameter int                   NUM_SRV    = 4,
  parameter int                   BASE       = 16,
  parameter int                   NUM_W      = 12,
  parameter int                   SRV_W      = 8,
  parameter logic [NUM_SRC-1:0]   LEVEL_MASK = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_vld,
  input  logic [2:0]        op_code,
  input  logic [NUM_W-1:0]  op_num,
  input  logic [SRV_W-1:0]  op_server,
  input  logic [PRIO_W:0]   op_prio,
  input  logic              op_val,
  output logic              busy,
  output logic              rsp_vld,
  output logic              rsp_err,
  output logic [SRV_W-1:0]  rsp_server,
  output logic [PRIO_W-1:0] rsp_prio,
  output logic              dlv_vld,
  input  logic              dlv_rdy,
  output logic [SRV_W-1:0]  dlv_server,
  output logic [NUM_W-1:0]  dlv_num,
  output logic [PRIO_W-1:0] dlv_prio
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] HI_N   = NUM_W'(BASE + NUM_SRC);

  // per-source state
  src_st_t           st_q    [NUM_SRC];
  logic [PRIO_W-1:0] prio_q  [NUM_SRC];
  logic [PRIO_W-1:0] sprio_q [NUM_SRC];
  logic [SRV_W-1:0]  srv_q   [NUM_SRC];

  op_e              op;
  logic             go, is_cfg, num_ok, srv_ok, prio_ok, cfg_err;
  logic [IDX_W-1:0] op_idx, a_idx, scan_idx;
  logic             scan_active, scan_ev;

  assign op      = op_e'(op_code);
  assign busy    = scan_active | dlv_vld;
  assign go      = op_vld && !busy;
  assign is_cfg  = (op == OP_SET) || (op == OP_GET) || (op == OP_MASK) || (op == OP_UNMASK);
  assign prio_ok = !op_prio[PRIO_W];
  assign cfg_err = !num_ok || ((op == OP_SET) && !(srv_ok && prio_ok));
  assign scan_ev = scan_active && !dlv_vld;
  assign a_idx   = scan_active ? scan_idx : op_idx;

  irq_src_range #(
    .NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .BASE(BASE),
    .NUM_W(NUM_W), .SRV_W(SRV_W), .IDX_W(IDX_W)
  ) u_range (
    .num(op_num), .server(op_server),
    .num_ok(num_ok), .srv_ok(srv_ok), .idx(op_idx)
  );

  irq_src_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst(rst),
    .start(go && (op == OP_REPLAY)),
    .step(scan_ev),
    .active(scan_active), .idx(scan_idx)
  );

  // next state of the one source touched this cycle
  src_st_t           n_st;
  logic [PRIO_W-1:0] n_prio, n_sprio;
  logic [SRV_W-1:0]  n_srv;
  logic              wr, fire, is_lvl;

  always_comb begin
    n_st    = st_q[a_idx];
    n_prio  = prio_q[a_idx];
    n_sprio = sprio_q[a_idx];
    n_srv   = srv_q[a_idx];
    is_lvl  = LEVEL_MASK[a_idx];
    wr      = 1'b0;
    fire    = 1'b0;
    if (scan_ev) begin
      wr = 1'b1;
      if (is_lvl) begin
        if (lvl_ready(n_st, n_prio)) begin n_st.sent = 1'b1; fire = 1'b1; end
      end else if (n_st.bnc) begin
        n_st.bnc = 1'b0;
        fire     = (n_prio != PRIO_OFF);
      end
    end else if (go && num_ok) begin
      case (op)
        OP_EVENT: begin
          wr = 1'b1;
          if (is_lvl) begin
            n_st.asrt = op_val;
            if (lvl_ready(n_st, n_prio)) begin n_st.sent = 1'b1; fire = 1'b1; end
          end else if (op_val) begin
            if (n_prio == PRIO_OFF) n_st.mpend = 1'b1;
            else                    fire = 1'b1;
          end
        end
        OP_SET, OP_UNMASK: begin
          if (op == OP_UNMASK) begin
            wr     = 1'b1;
            n_prio = n_sprio;
          end else if (srv_ok && prio_ok) begin
            wr      = 1'b1;
            n_srv   = op_server;
            n_prio  = op_prio[PRIO_W-1:0];
            n_sprio = op_prio[PRIO_W-1:0];
          end
          if (wr) begin
            if (is_lvl) begin
              if (lvl_ready(n_st, n_prio)) begin n_st.sent = 1'b1; fire = 1'b1; end
            end else if (n_st.mpend && (n_prio != PRIO_OFF)) begin
              n_st.mpend = 1'b0;
              fire       = 1'b1;
            end
          end
        end
        OP_MASK: begin
          wr      = 1'b1;
          n_sprio = n_prio;
          n_prio  = PRIO_OFF;
        end
        OP_BOUNCE: begin
          wr        = 1'b1;
          n_st.bnc  = 1'b1;
          n_st.sent = 1'b0;
        end
        OP_EOI: begin
          if (is_lvl) begin wr = 1'b1; n_st.sent = 1'b0; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        st_q[i]    <= '0;
        prio_q[i]  <= PRIO_OFF;
        sprio_q[i] <= PRIO_OFF;
        srv_q[i]   <= '0;
      end
    end else if (wr) begin
      st_q[a_idx]    <= n_st;
      prio_q[a_idx]  <= n_prio;
      sprio_q[a_idx] <= n_sprio;
      srv_q[a_idx]   <= n_srv;
    end
  end

  // delivery register
  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_vld    <= 1'b0;
      dlv_server <= '0;
      dlv_num    <= '0;
      dlv_prio   <= '0;
    end else begin
      if (dlv_vld && dlv_rdy) dlv_vld <= 1'b0;
      if (fire) begin
        dlv_vld    <= 1'b1;
        dlv_server <= n_srv;
        dlv_num    <= NUM_W'(a_idx) + BASE_N;
        dlv_prio   <= n_prio;
      end
    end
  end

  // configuration response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      rsp_vld    <= go && is_cfg;
      rsp_err    <= cfg_err;
      rsp_server <= srv_q[op_idx];
      rsp_prio   <= prio_q[op_idx];
    end
  end

  // R8: a waiting request keeps its fields
  p_dlv_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dlv_vld && !dlv_rdy) |=> (dlv_vld && $stable(dlv_num) && $stable(dlv_prio) && $stable(dlv_server)));
  // R2: a masked source never reaches the delivery port
  p_no_masked_dlv_r2: assert property (@(posedge clk) disable iff (rst)
    dlv_vld |-> (dlv_prio != PRIO_OFF));
  // R3: delivered numbers are absolute and inside the bank
  p_dlv_num_r3: assert property (@(posedge clk) disable iff (rst)
    dlv_vld |-> ((dlv_num >= BASE_N) && (dlv_num < HI_N)));
  // R11: responses only follow an accepted operation
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> $past(op_vld && !busy));
  // R8: nothing is accepted while a request is waiting
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (dlv_vld && !dlv_rdy) |=> !rsp_vld);
endmodule

// File: tb/irq_src_ctrl_bench.sv
module irq_src_ctrl_bench;
  localparam int NUM_W = 12;
  localparam int SRV_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_vld = 1'b0;
  logic [2:0] op_code = '0;
  logic [NUM_W-1:0] op_num = '0;
  logic [SRV_W-1:0] op_server = '0;
  logic [8:0] op_prio = '0;
  logic op_val = 1'b0;
  logic dlv_rdy = 1'b0;
  logic busy, rsp_vld, rsp_err, dlv_vld;
  logic [SRV_W-1:0] rsp_server, dlv_server;
  logic [7:0] rsp_prio, dlv_prio;
  logic [NUM_W-1:0] dlv_num;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_src_ctrl u_irq_src_ctrl (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_code(op_code), .op_num(op_num),
    .op_server(op_server), .op_prio(op_prio), .op_val(op_val), .busy(busy),
    .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .dlv_vld(dlv_vld), .dlv_rdy(dlv_rdy), .dlv_server(dlv_server), .dlv_num(dlv_num),
    .dlv_prio(dlv_prio)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  op;
    logic [11:0] num;
    logic [7:0]  srv;
    logic [8:0]  prio;
    logic        val;
    logic        e_dlv;
    logic [11:0] e_dnum;
    logic [7:0]  e_dsrv;
    logic [7:0]  e_dprio;
    logic        e_rsp;
    logic        e_err;
    logic [7:0]  e_rsrv;
    logic [7:0]  e_rprio;
  } vec_t;

  localparam int NV = 26;
  // op: 0 event 1 set 2 read 3 mask 4 unmask 5 bounce 6 eoi
  localparam vec_t VECS [NV] = '{
    '{8'd3,  3'd1, 12'd16, 8'd2, 9'd5,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd0, 8'd0},   // R3 setup
    '{8'd3,  3'd0, 12'd16, 8'd0, 9'd0,   1'b1, 1'b1, 12'd16, 8'd2, 8'd5,   1'b0, 1'b0, 8'd0, 8'd0},   // R3
    '{8'd2,  3'd1, 12'd17, 8'd1, 9'd255, 1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd0, 8'd0},   // R2
    '{8'd2,  3'd0, 12'd17, 8'd0, 9'd0,   1'b1, 1'b0, 12'd0,  8'd0, 8'd0,   1'b0, 1'b0, 8'd0, 8'd0},   // R2
    '{8'd2,  3'd1, 12'd17, 8'd1, 9'd3,   1'b0, 1'b1, 12'd17, 8'd1, 8'd3,   1'b1, 1'b0, 8'd0, 8'd0},   // R2
    '{8'd2,  3'd1, 12'd17, 8'd1, 9'd3,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd0, 8'd0},   // R2
    '{8'd4,  3'd1, 12'd20, 8'd3, 9'd7,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd0, 8'd0},   // R4
    '{8'd4,  3'd0, 12'd20, 8'd0, 9'd0,   1'b1, 1'b1, 12'd20, 8'd3, 8'd7,   1'b0, 1'b0, 8'd0, 8'd0},   // R4
    '{8'd4,  3'd0, 12'd20, 8'd0, 9'd0,   1'b1, 1'b0, 12'd0,  8'd0, 8'd0,   1'b0, 1'b0, 8'd0, 8'd0},   // R4
    '{8'd4,  3'd0, 12'd20, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b0, 1'b0, 8'd0, 8'd0},   // R4
    '{8'd4,  3'd0, 12'd20, 8'd0, 9'd0,   1'b1, 1'b0, 12'd0,  8'd0, 8'd0,   1'b0, 1'b0, 8'd0, 8'd0},   // R4
    '{8'd5,  3'd6, 12'd20, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b0, 1'b0, 8'd0, 8'd0},   // R5
    '{8'd5,  3'd0, 12'd20, 8'd0, 9'd0,   1'b1, 1'b1, 12'd20, 8'd3, 8'd7,   1'b0, 1'b0, 8'd0, 8'd0},   // R5
    '{8'd11, 3'd2, 12'd20, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd3, 8'd7},   // R11
    '{8'd9,  3'd3, 12'd20, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd0, 8'd0},   // R9
    '{8'd9,  3'd2, 12'd20, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd3, 8'd255}, // R9
    '{8'd5,  3'd6, 12'd20, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b0, 1'b0, 8'd0, 8'd0},   // R5
    '{8'd9,  3'd0, 12'd20, 8'd0, 9'd0,   1'b1, 1'b0, 12'd0,  8'd0, 8'd0,   1'b0, 1'b0, 8'd0, 8'd0},   // R9
    '{8'd9,  3'd4, 12'd20, 8'd0, 9'd0,   1'b0, 1'b1, 12'd20, 8'd3, 8'd7,   1'b1, 1'b0, 8'd0, 8'd0},   // R9
    '{8'd9,  3'd2, 12'd20, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd3, 8'd7},   // R9
    '{8'd10, 3'd1, 12'd24, 8'd0, 9'd1,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b1, 8'd0, 8'd0},   // R10
    '{8'd10, 3'd1, 12'd18, 8'd4, 9'd1,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b1, 8'd0, 8'd0},   // R10
    '{8'd10, 3'd1, 12'd18, 8'd0, 9'd256, 1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b1, 8'd0, 8'd0},   // R10
    '{8'd10, 3'd2, 12'd18, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b0, 8'd0, 8'd255}, // R10
    '{8'd10, 3'd2, 12'd15, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b1, 8'd0, 8'd0},   // R10
    '{8'd10, 3'd3, 12'd24, 8'd0, 9'd0,   1'b0, 1'b0, 12'd0,  8'd0, 8'd0,   1'b1, 1'b1, 8'd0, 8'd0}    // R10
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one operation for one cycle; returns at the negedge after acceptance
  task automatic do_op(input logic [2:0] c, input logic [11:0] n, input logic [7:0] s,
                       input logic [8:0] p, input logic v);
    @(negedge clk);
    op_vld = 1'b1; op_code = c; op_num = n; op_server = s; op_prio = p; op_val = v;
    @(negedge clk);
    op_vld = 1'b0;
  endtask

  task automatic take_dlv();
    if (dlv_vld) begin
      dlv_rdy = 1'b1;
      @(negedge clk);
      dlv_rdy = 1'b0;
    end
  endtask

  // issue a replay and collect deliveries until busy drops
  int rp_cnt, rp_busy;
  logic [11:0] rp_num [4];
  logic [7:0]  rp_srv [4];
  logic [7:0]  rp_prio [4];
  task automatic replay();
    rp_cnt = 0; rp_busy = 0;
    do_op(3'd7, 12'd0, 8'd0, 9'd0, 1'b0);
    while (busy && rp_busy < 200) begin
      rp_busy++;
      if (dlv_vld) begin
        if (rp_cnt < 4) begin
          rp_num[rp_cnt] = dlv_num; rp_srv[rp_cnt] = dlv_server; rp_prio[rp_cnt] = dlv_prio;
        end
        rp_cnt++;
        dlv_rdy = 1'b1;
      end else begin
        dlv_rdy = 1'b0;
      end
      @(negedge clk);
    end
    dlv_rdy = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(1, "busy after reset", 32'(busy), 0);
    chk(1, "dlv_vld after reset", 32'(dlv_vld), 0);
    chk(1, "rsp_vld after reset", 32'(rsp_vld), 0);
    for (int i = 16; i < 24; i++) begin
      do_op(3'd2, 12'(i), 8'd0, 9'd0, 1'b0);
      chk(1, "reset read rsp", 32'(rsp_vld), 1);
      chk(1, "reset read prio", 32'(rsp_prio), 32'hFF);
      chk(1, "reset read server", 32'(rsp_server), 0);
    end

    // table walk
    for (int k = 0; k < NV; k++) begin
      do_op(VECS[k].op, VECS[k].num, VECS[k].srv, VECS[k].prio, VECS[k].val);
      chk(int'(VECS[k].req), $sformatf("vec %0d dlv_vld", k), 32'(dlv_vld), 32'(VECS[k].e_dlv));
      if (VECS[k].e_dlv) begin
        chk(int'(VECS[k].req), $sformatf("vec %0d dlv_num", k), 32'(dlv_num), 32'(VECS[k].e_dnum));
        chk(int'(VECS[k].req), $sformatf("vec %0d dlv_server", k), 32'(dlv_server), 32'(VECS[k].e_dsrv));
        chk(int'(VECS[k].req), $sformatf("vec %0d dlv_prio", k), 32'(dlv_prio), 32'(VECS[k].e_dprio));
      end
      chk(int'(VECS[k].req), $sformatf("vec %0d rsp_vld", k), 32'(rsp_vld), 32'(VECS[k].e_rsp));
      if (VECS[k].e_rsp) begin
        chk(int'(VECS[k].req), $sformatf("vec %0d rsp_err", k), 32'(rsp_err), 32'(VECS[k].e_err));
        if (VECS[k].op == 3'd2 && !VECS[k].e_err) begin
          chk(int'(VECS[k].req), $sformatf("vec %0d rsp_server", k), 32'(rsp_server), 32'(VECS[k].e_rsrv));
          chk(int'(VECS[k].req), $sformatf("vec %0d rsp_prio", k), 32'(rsp_prio), 32'(VECS[k].e_rprio));
        end
      end
      take_dlv();
    end

    // R6 / R7: bounce level 20 and message 16, then replay
    do_op(3'd5, 12'd20, 8'd0, 9'd0, 1'b0);
    chk(6, "bounce gives no delivery", 32'(dlv_vld), 0);
    do_op(3'd5, 12'd16, 8'd0, 9'd0, 1'b0);
    chk(6, "bounce gives no response", 32'(rsp_vld), 0);
    replay();
    chk(6, "replay delivery count", 32'(rp_cnt), 2);
    chk(7, "first replay delivery is 16", 32'(rp_num[0]), 16);
    chk(6, "first replay server", 32'(rp_srv[0]), 2);
    chk(6, "first replay prio", 32'(rp_prio[0]), 5);
    chk(7, "second replay delivery is 20", 32'(rp_num[1]), 20);
    chk(6, "second replay prio", 32'(rp_prio[1]), 7);

    // R5 / R6 / R7: end-of-interrupt on a message changes nothing; bounce consumed once
    do_op(3'd6, 12'd16, 8'd0, 9'd0, 1'b0);
    chk(5, "message eoi no delivery", 32'(dlv_vld), 0);
    replay();
    chk(6, "second replay delivers nothing", 32'(rp_cnt), 0);
    chk(7, "replay busy cycles", 32'(rp_busy), 8);

    // R8: backpressure and operations ignored while busy
    do_op(3'd0, 12'd16, 8'd0, 9'd0, 1'b1);
    chk(8, "held delivery valid", 32'(dlv_vld), 1);
    op_vld = 1'b1; op_code = 3'd0; op_num = 12'd17; op_val = 1'b1;
    @(negedge clk);
    op_code = 3'd2;
    @(negedge clk);
    chk(8, "no response while busy", 32'(rsp_vld), 0);
    op_vld = 1'b0;
    @(negedge clk);
    chk(8, "delivery still held", 32'(dlv_vld), 1);
    chk(8, "held number stable", 32'(dlv_num), 16);
    chk(8, "busy while held", 32'(busy), 1);
    take_dlv();
    chk(8, "delivery released", 32'(dlv_vld), 0);
    @(negedge clk);
    chk(8, "ignored event gave no delivery", 32'(dlv_vld), 0);
    chk(8, "busy released", 32'(busy), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule